// File: doc/BRIEF.md
# Camera-to-VGA Line Doubling Buffer

This block carries 8-bit luminance samples from a camera running on its own pixel clock, about 17 MHz, to a 25 MHz VGA pixel stream. It scales the picture by two in each direction. Every stored camera pixel fills two neighbouring VGA pixel slots, and every stored camera line is shown on two VGA lines in a row. A camera line is 352 samples long and a frame has 288 lines. Only a 320 x 240 window is kept, which fills a 640 x 480 screen exactly.

Storage is a two-clock memory with one write-only port and one read-only port. It is split into two line banks, and the bank is chosen by one extra address bit. The camera fills one bank while the display reads the other. When a camera line completes, the bank bit flips and a toggle is sent across to the VGA clock domain through a two-flop synchronizer. At a later VGA line start, the display side takes up the newly completed bank. The display timing itself (line start and display enable) is produced outside the block.

Top module: `line_double_buf`

## Requirements
- R1: After reset, `vga_pix` is 0 and stays 0 until at least one camera line has completed and been taken up at a VGA line start.
- R2: Count the display-enable cycles since the last `vga_line_start` as slot j, starting from 0. Slot j shows stored pixel j/2 (rounded down) of the displayed line. The value appears on `vga_pix` one `vga_clk` cycle after the slot's display-enable cycle.
- R3: A newly taken camera line is shown on exactly two consecutive VGA lines before any newer line replaces it.
- R4: A camera line completes on its `LINE_PIX`-th valid sample after the most recent line start. On completion the write bank flips, so the next line fills the other bank. After the current line's two passes, the next VGA line start takes up the newest completed line.
- R5: Camera samples at positions `SHOW_PIX` and above within a line are not stored. VGA slots at 2*`SHOW_PIX` and above show 0.
- R6: Lines after the first `SHOW_LINES` lines of a frame are not stored and complete no line, so the display keeps showing the last kept line.
- R7: If no new line has completed when a VGA line start follows the second pass, the last taken bank is shown again.
- R8: In any cycle after one in which `vga_de` was low, `vga_pix` is 0. The slot count does not advance while `vga_de` is low.
- R9: `cam_frame_start` restarts the line count of the frame, so the following lines are stored and shown again.
- R10: A line cut short by a new `cam_line_start` before `LINE_PIX` valid samples does not complete and is never shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cam_clk | input | 1 | Camera pixel clock |
| cam_rst_n | input | 1 | Active-low asynchronous reset, camera domain |
| cam_frame_start | input | 1 | One-cycle strobe at the start of a camera frame |
| cam_line_start | input | 1 | One-cycle strobe at the start of a camera line |
| cam_valid | input | 1 | `cam_pix` carries a sample this cycle |
| cam_pix | input | PIX_W | Luminance sample |
| vga_clk | input | 1 | VGA pixel clock |
| vga_rst_n | input | 1 | Active-low asynchronous reset, VGA domain |
| vga_line_start | input | 1 | One-cycle strobe before the display-enable part of a VGA line |
| vga_de | input | 1 | VGA display enable |
| vga_pix | output | PIX_W | Pixel shown, one cycle after its display-enable cycle |

## Verification
The bench goes after the pixel pairing and the exact two-pass rule. A design that is off by one in the slot-to-pixel mapping shifts the whole line. A design that takes up a new bank too early shows a line only once. The bench also feeds samples beyond the kept width: a design that does not clip them overwrites the start of the bank with later samples. Further tests cover a short line, the lines past the vertical limit and a frame restart. A design that miscounts any of these shows the wrong line. A display-enable gap in mid-line exposes a design that lets the slot count run during blanking or leaves stale data on the output.

// File: rtl/line_double_buf.sv
module line_double_buf #(
  parameter int PIX_W      = 8,
  parameter int LINE_PIX   = 352,
  parameter int SHOW_PIX   = 320,
  parameter int SHOW_LINES = 240
) (
  input  logic             cam_clk,
  input  logic             cam_rst_n,
  input  logic             cam_frame_start,
  input  logic             cam_line_start,
  input  logic             cam_valid,
  input  logic [PIX_W-1:0] cam_pix,
  input  logic             vga_clk,
  input  logic             vga_rst_n,
  input  logic             vga_line_start,
  input  logic             vga_de,
  output logic [PIX_W-1:0] vga_pix
);
  localparam int AW = $clog2(SHOW_PIX);
  localparam int CW = $clog2(LINE_PIX);
  localparam int RW = $clog2(SHOW_LINES + 1);
  localparam int HW = $clog2(2 * SHOW_PIX + 1);
  localparam int DEPTH = 2 * (2 ** AW);

  logic [PIX_W-1:0] mem [0:DEPTH-1];

  // camera side
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          bank_w;

  wire strobe   = cam_frame_start || cam_line_start;
  wire row_ok   = row < RW'(SHOW_LINES);
  wire wr_en    = cam_valid && !strobe && (col < CW'(SHOW_PIX)) && row_ok;
  wire line_end = cam_valid && (col == CW'(LINE_PIX - 1));

  always_ff @(posedge cam_clk or negedge cam_rst_n) begin
    if (!cam_rst_n) begin
      col    <= '0;
      row    <= '0;
      bank_w <= 1'b0;
    end else if (cam_frame_start) begin
      col <= '0;
      row <= '0;
    end else if (cam_line_start) begin
      col <= '0;
    end else if (line_end) begin
      col <= '0;
      if (row_ok) begin
        row    <= row + 1'b1;
        bank_w <= ~bank_w;
      end
    end else if (cam_valid) begin
      col <= col + 1'b1;
    end
  end

  always_ff @(posedge cam_clk)
    if (wr_en) mem[{bank_w, col[AW-1:0]}] <= cam_pix;

  // display side
  logic          s1, s2, s3;
  logic          pend, rep, have, bank_r;
  logic [HW-1:0] hcnt;
  logic [PIX_W-1:0] rd_q;
  logic          show_q;

  wire fresh = s2 ^ s3;
  wire take  = vga_line_start && rep && (pend || fresh);

  always_ff @(posedge vga_clk or negedge vga_rst_n) begin
    if (!vga_rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      s3     <= 1'b0;
      pend   <= 1'b0;
      rep    <= 1'b1;
      have   <= 1'b0;
      bank_r <= 1'b0;
      hcnt   <= '0;
      show_q <= 1'b0;
    end else begin
      s1     <= bank_w;
      s2     <= s1;
      s3     <= s2;
      pend   <= take ? 1'b0 : (pend || fresh);
      show_q <= vga_de && have && (hcnt < HW'(2 * SHOW_PIX));
      if (vga_line_start) begin
        hcnt <= '0;
        if (take) begin
          bank_r <= ~s2;
          rep    <= 1'b0;
          have   <= 1'b1;
        end else begin
          rep <= 1'b1;
        end
      end else if (vga_de && hcnt != HW'(2 * SHOW_PIX)) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge vga_clk)
    rd_q <= mem[{bank_r, hcnt[AW:1]}];

  assign vga_pix = show_q ? rd_q : '0;

  // R1: nothing is shown before a line is taken up
  a_r1_dark_start: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    !have |=> (vga_pix == '0));
  // R3: the second pass keeps the bank
  a_r3_second_pass: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    (vga_line_start && !rep) |=> $stable(bank_r));
  // R7: no new line means the bank is held
  a_r7_replay: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    (vga_line_start && !pend && !fresh) |=> $stable(bank_r));
  // R8: blanking gives zero
  a_r8_blank: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    !vga_de |=> (vga_pix == '0));
  // R4: bank flips only at a line completion
  a_r4_flip_at_end: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    !$stable(bank_w) |-> (col == '0));
  // R6: no completion past the vertical limit
  a_r6_vclip: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    (row == RW'(SHOW_LINES) && !cam_frame_start) |=> $stable(bank_w));
endmodule

// File: tb/line_double_buf_bench.sv
module line_double_buf_bench;
  localparam int CAM_PERIOD = 58;
  localparam int VGA_PERIOD = 40;
  localparam int LP    = 24;
  localparam int SP    = 16;
  localparam int SL    = 6;
  localparam int SLOTS = 2 * SP + 4;

  logic cclk = 0, vclk = 0;
  logic cam_rst_n = 0, vga_rst_n = 0;
  logic cam_frame_start = 0, cam_line_start = 0, cam_valid = 0;
  logic [7:0] cam_pix = 0;
  logic vga_line_start = 0, vga_de = 0;
  logic [7:0] vga_pix;
  int checks = 0, fails = 0;

  always #(CAM_PERIOD / 2) cclk = ~cclk;
  always #(VGA_PERIOD / 2) vclk = ~vclk;

  line_double_buf #(.PIX_W(8), .LINE_PIX(LP), .SHOW_PIX(SP), .SHOW_LINES(SL)) u_line_double_buf (
    .cam_clk(cclk), .cam_rst_n(cam_rst_n), .cam_frame_start(cam_frame_start),
    .cam_line_start(cam_line_start), .cam_valid(cam_valid), .cam_pix(cam_pix),
    .vga_clk(vclk), .vga_rst_n(vga_rst_n), .vga_line_start(vga_line_start),
    .vga_de(vga_de), .vga_pix(vga_pix));

  // {pixel count, camera seed, expected seed on screen}
  localparam logic [23:0] VEC [5] = '{
    {8'd24, 8'h10, 8'h10},
    {8'd24, 8'h53, 8'h53},
    {8'd10, 8'h77, 8'h53},
    {8'd24, 8'hA0, 8'hA0},
    {8'd24, 8'hF0, 8'hF0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cam_line(input logic [7:0] seed, input int npix);
    @(negedge cclk) cam_line_start = 1;
    @(negedge cclk) cam_line_start = 0;
    for (int k = 0; k < npix; k++) begin
      if (k % 5 == 3) begin
        @(negedge cclk) cam_valid = 0;
      end
      @(negedge cclk);
      cam_valid = 1;
      cam_pix = 8'(seed + k);
    end
    @(negedge cclk) cam_valid = 0;
    repeat (2) @(negedge cclk);
    repeat (8) @(negedge vclk);
  endtask

  task automatic vga_line(input logic [7:0] seed, input bit on, input int gap, input string tag);
    int nbad = 0;
    int idx = 0;
    int pidx = 0;
    bit pde = 0;
    logic [7:0] e, fa, fe;
    fa = 0; fe = 0;
    @(negedge vclk) vga_line_start = 1;
    @(negedge vclk) vga_line_start = 0;
    @(negedge vclk);
    for (int t = 0; t < SLOTS + 5; t++) begin
      @(negedge vclk);
      if (t > 0) begin
        e = (pde && on && pidx < 2 * SP) ? 8'(seed + pidx / 2) : 8'h00;
        if (vga_pix !== e) begin
          if (nbad == 0) begin fa = vga_pix; fe = e; end
          nbad++;
        end
      end
      pde = (idx < SLOTS) && !(gap >= 0 && t >= gap && t < gap + 3);
      vga_de = pde;
      pidx = idx;
      if (pde) idx++;
    end
    vga_de = 0;
    chk(nbad == 0, tag, fa, fe);
  endtask

  initial begin
    #(VGA_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge vclk);
    cam_rst_n = 1;
    vga_rst_n = 1;
    repeat (2) @(negedge vclk);
    chk(vga_pix == 8'h00, "R1 reset output", vga_pix, 0);
    vga_line(8'h00, 0, -1, "R1 dark before first line");

    @(negedge cclk) cam_frame_start = 1;
    @(negedge cclk) cam_frame_start = 0;
    for (int i = 0; i < 5; i++) begin
      cam_line(VEC[i][15:8], int'(VEC[i][23:16]));
      vga_line(VEC[i][7:0], 1, -1, (VEC[i][23:16] == 8'd24) ? "R2 R4 R5 first pass" : "R10 short line hidden");
      vga_line(VEC[i][7:0], 1, -1, "R3 second pass");
    end

    vga_line(8'hF0, 1, -1, "R7 replay without new line");
    vga_line(8'hF0, 1, 9, "R8 enable gap");

    cam_line(8'h21, LP);
    vga_line(8'h21, 1, -1, "R4 line five");
    vga_line(8'h21, 1, -1, "R3 line five again");
    cam_line(8'h32, LP);
    vga_line(8'h32, 1, -1, "R4 last kept line");
    vga_line(8'h32, 1, -1, "R3 last kept again");
    cam_line(8'h43, LP);
    vga_line(8'h32, 1, -1, "R6 line past limit");

    @(negedge cclk) cam_frame_start = 1;
    @(negedge cclk) cam_frame_start = 0;
    cam_line(8'h54, LP);
    vga_line(8'h54, 1, -1, "R9 new frame");
    vga_line(8'h54, 1, -1, "R9 new frame second pass");

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule